// File: doc/BRIEF.md
# Multithreaded Fetch Thread-Status Controller

This block holds one status state machine per hardware thread of a multithreaded instruction fetch stage. Each cycle it collects stall and release pulses from the four downstream stages, redirect requests from the commit and decode stages, a commit-side "still flushing" level, the request outcomes of the fetch datapath (issued, refused, retried), trap and quiesce requests, and instruction-cache responses that carry a thread number and a request tag. From these it selects each thread's next status and drives one stage-wide activity flag. The flag tells the core's clock-gating logic whether fetch has any useful work.

Every decision is made from the registered state of the previous cycle. All transitions take effect on one clock edge. Per thread, the sources are resolved in a fixed priority order: thread disable, commit redirect, commit flushing, decode redirect, cache fill, stall, and then the thread's own progress. A cache response is only accepted when the thread is still waiting for it and the tag matches the request currently outstanding. This discards responses that belong to requests cancelled by a redirect. Only one thread at a time may hold the refused-request retry slot.

States (4-bit code): RUN=0, IDLE=1, SQUASH=2, BLOCK=3, WAIT_RSP=4, WAIT_RETRY=5, FILL_DONE=6, TRAP=7, QUIESCE=8.

Transitions:
- any → IDLE when the thread is disabled.
- any → SQUASH on a commit redirect, on commit flushing, or on a decode redirect.
- WAIT_RSP → FILL_DONE or BLOCK on an accepted fill.
- → BLOCK on a stall.
- BLOCK, SQUASH or IDLE → RUN on release.
- RUN → TRAP, QUIESCE, WAIT_RSP (request issued) or WAIT_RETRY (request refused, slot won).
- WAIT_RETRY → WAIT_RSP on retry grant.
- FILL_DONE → RUN.
- TRAP or QUIESCE → RUN on wake.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is RUN (code 0). Its redirect address is 0, its request tag is 0 and its line-valid bit is clear. The retry slot is free, all stall flags are clear, and with all threads enabled stage_active is 1.
- R2: Each thread has four sticky stall flags, indexed in stall_set/stall_clr at bit thread*4+source (source 0 decode, 1 rename, 2 execute, 3 commit). A set pulse raises the flag and a clear pulse drops it. A clear pulse is legal only when the flag is up and no set pulse for that flag arrives in the same cycle. A flag that is still raised keeps the thread stalled after another flag of that thread is cleared. A flag raised at edge k affects the status at edge k+1, not at edge k.
- R3: A commit redirect has the highest priority for an enabled thread. At the next edge the thread is SQUASH and holds the commit address, even if a decode redirect, a stall or a fill arrives in the same cycle.
- R4: While commit flushing is high the thread stays SQUASH. A decode redirect that arrives while the thread is already SQUASH does not change its address.
- R5: A decode redirect to a thread that is not SQUASH loads the decode address and moves the thread to SQUASH.
- R6: A stall (any flag of the thread, or the global context-switch input, which acts on the same edge) moves RUN, BLOCK, FILL_DONE or IDLE to BLOCK. WAIT_RSP, WAIT_RETRY, TRAP and QUIESCE are held instead.
- R7: A thread in BLOCK, SQUASH or IDLE with no disable, redirect, flush or stall returns to RUN at the next edge.
- R8: An accepted fill sets the thread's line-valid bit. It moves the thread to BLOCK if a stall is active and to FILL_DONE otherwise. FILL_DONE becomes RUN at the next edge.
- R9: A response is dropped (rsp_drop high in that cycle, no change of status or line-valid) when the thread is not WAIT_RSP, when the tag differs from the thread's current request tag, when switched_out is high, or when a redirect or flush to that thread takes priority.
- R10: A thread in RUN with req_issue goes to WAIT_RSP. A thread in RUN with req_refuse goes to WAIT_RETRY only if the retry slot is free, and the lowest-numbered contender wins. Each new request increments the thread's tag and clears its line-valid bit. retry_grant moves the slot owner to WAIT_RSP and frees the slot.
- R11: A redirect abandons an outstanding miss of that thread, so its later response is dropped. It also frees the retry slot if that thread owns it.
- R12: stage_active is 1 exactly when some enabled thread is RUN, SQUASH or FILL_DONE.
- R13: trap_req or quiesce_req moves a RUN thread to TRAP or QUIESCE, and wake returns it to RUN. A disabled thread becomes IDLE, and when it is enabled again it returns to RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_enable | input | NT | Thread enabled |
| stall_set | input | 4*NT | Stall flag set pulses, bit thread*4+source |
| stall_clr | input | 4*NT | Stall flag clear pulses, same layout |
| ctx_switch | input | 1 | Global context switch, stalls every thread |
| cmt_redirect | input | NT | Redirect from commit |
| cmt_redirect_pc | input | NT*PC_W | Commit redirect address per thread |
| cmt_flushing | input | NT | Commit still flushing |
| dec_redirect | input | NT | Redirect from decode |
| dec_redirect_pc | input | NT*PC_W | Decode redirect address per thread |
| req_issue | input | NT | Line request accepted by the cache |
| req_refuse | input | NT | Line request refused, retry needed |
| retry_grant | input | 1 | Cache ready to take the retried request |
| rsp_valid | input | 1 | Cache response present |
| rsp_tid | input | TID_W | Response thread number |
| rsp_tag | input | TAG_W | Response request tag |
| switched_out | input | 1 | Stage switched out; responses are dropped |
| trap_req | input | NT | Enter trap wait |
| quiesce_req | input | NT | Enter quiesce wait |
| wake | input | NT | Leave trap or quiesce wait |
| thr_state | output | 4*NT | Thread status codes, 4 bits per thread |
| thr_pc | output | NT*PC_W | Last redirect address per thread |
| req_tag | output | NT*TAG_W | Current request tag per thread |
| line_valid | output | NT | Thread line buffer holds fill data |
| rsp_drop | output | 1 | Present response is discarded |
| retry_busy | output | 1 | Retry slot is held |
| retry_owner | output | TID_W | Thread holding the retry slot |
| stage_active | output | 1 | Fetch stage has useful work |

## Verification
The bench drives simultaneous commit and decode redirects with different addresses. A design with the priority reversed would end with the decode address. It also sends a decode redirect to a thread that is still flushing, where a wrong design would overwrite the address. It sends responses with a stale tag, with switched_out, to a thread that is not waiting, and after a redirect has abandoned a miss. A design that checks any of these badly fills the line or moves the thread to FILL_DONE. Two threads are refused in the same cycle: a broken slot lets both wait or frees the slot late. A stall raised during a miss must not leave WAIT_RSP, and it must turn the later fill into BLOCK instead of FILL_DONE.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [3:0] {
        FS_RUN        = 4'd0,
        FS_IDLE       = 4'd1,
        FS_SQUASH     = 4'd2,
        FS_BLOCK      = 4'd3,
        FS_WAIT_RSP   = 4'd4,
        FS_WAIT_RETRY = 4'd5,
        FS_FILL_DONE  = 4'd6,
        FS_TRAP       = 4'd7,
        FS_QUIESCE    = 4'd8
    } fstate_e;

    localparam int STATE_W   = 4;
    localparam int STALL_SRC = 4;

endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] flag_o
);

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            logic f_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    f_q <= 1'b0;
                else if (set_i[s])
                    f_q <= 1'b1;
                else if (clr_i[s])
                    f_q <= 1'b0;
            end

            assign flag_o[s] = f_q;

            AST_CLEAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
                clr_i[s] |-> (f_q && !set_i[s])); // R2
        end
    endgenerate

endmodule

// File: rtl/fsc_retry_slot.sv
module fsc_retry_slot #(
    parameter int NT    = 2,
    parameter int TID_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    ask_i,
    input  logic [NT-1:0]    leave_i,
    output logic [NT-1:0]    won_o,
    output logic             busy_o,
    output logic [TID_W-1:0] owner_o
);

    logic             busy_q;
    logic [TID_W-1:0] owner_q;
    logic [TID_W-1:0] pick;
    logic             any_ask;

    always_comb begin
        won_o   = '0;
        pick    = '0;
        any_ask = 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (ask_i[t] && !any_ask && !busy_q) begin
                any_ask  = 1'b1;
                won_o[t] = 1'b1;
                pick     = TID_W'(t);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
        end else if (busy_q) begin
            if (leave_i[owner_q])
                busy_q <= 1'b0;
        end else if (any_ask) begin
            busy_q  <= 1'b1;
            owner_q <= pick;
        end
    end

    assign busy_o  = busy_q;
    assign owner_o = owner_q;

    AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(won_o) && !(busy_q && |won_o)); // R10

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             stall_i,
    input  logic             cmt_redir_i,
    input  logic [PC_W-1:0]  cmt_pc_i,
    input  logic             cmt_flush_i,
    input  logic             dec_redir_i,
    input  logic [PC_W-1:0]  dec_pc_i,
    input  logic             issue_i,
    input  logic             refuse_i,
    input  logic             slot_won_i,
    input  logic             grant_i,
    input  logic             trap_i,
    input  logic             quiesce_i,
    input  logic             wake_i,
    input  logic             rsp_here_i,
    input  logic [TAG_W-1:0] rsp_tag_i,
    input  logic             switched_out_i,
    output logic [STATE_W-1:0] state_o,
    output logic [PC_W-1:0]  pc_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             line_valid_o,
    output logic             rsp_take_o,
    output logic             slot_ask_o,
    output logic             slot_leave_o
);

    fstate_e          st_q, st_d;
    logic [PC_W-1:0]  pc_q;
    logic [TAG_W-1:0] tag_q;
    logic             lv_q;

    logic             load_pc;
    logic [PC_W-1:0]  new_pc;
    logic             new_req;
    logic             take;
    logic             hold_in_stall;

    assign hold_in_stall = (st_q == FS_WAIT_RSP) || (st_q == FS_WAIT_RETRY) ||
                           (st_q == FS_TRAP)     || (st_q == FS_QUIESCE);

    // Next-state decision, fixed priority
    always_comb begin
        st_d    = st_q;
        load_pc = 1'b0;
        new_pc  = cmt_pc_i;
        new_req = 1'b0;
        take    = 1'b0;
        if (!enable_i) begin
            st_d = FS_IDLE;
        end else if (cmt_redir_i) begin
            st_d    = FS_SQUASH;
            load_pc = 1'b1;
            new_pc  = cmt_pc_i;
        end else if (cmt_flush_i) begin
            st_d = FS_SQUASH;
        end else if (dec_redir_i && st_q != FS_SQUASH) begin
            st_d    = FS_SQUASH;
            load_pc = 1'b1;
            new_pc  = dec_pc_i;
        end else if (rsp_here_i && st_q == FS_WAIT_RSP &&
                     rsp_tag_i == tag_q && !switched_out_i) begin
            take = 1'b1;
            st_d = stall_i ? FS_BLOCK : FS_FILL_DONE;
        end else if (stall_i && !hold_in_stall) begin
            st_d = FS_BLOCK;
        end else begin
            unique case (st_q)
                FS_BLOCK, FS_SQUASH, FS_IDLE: st_d = FS_RUN;
                FS_RUN: begin
                    if (trap_i)
                        st_d = FS_TRAP;
                    else if (quiesce_i)
                        st_d = FS_QUIESCE;
                    else if (issue_i) begin
                        st_d    = FS_WAIT_RSP;
                        new_req = 1'b1;
                    end else if (slot_won_i) begin
                        st_d    = FS_WAIT_RETRY;
                        new_req = 1'b1;
                    end
                end
                FS_WAIT_RETRY: if (grant_i) st_d = FS_WAIT_RSP;
                FS_FILL_DONE:  st_d = FS_RUN;
                FS_TRAP, FS_QUIESCE: if (wake_i) st_d = FS_RUN;
                FS_WAIT_RSP:   st_d = FS_WAIT_RSP;
                default:       st_d = FS_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FS_RUN;
            pc_q  <= '0;
            tag_q <= '0;
            lv_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load_pc)
                pc_q <= new_pc;
            if (new_req) begin
                tag_q <= tag_q + 1'b1;
                lv_q  <= 1'b0;
            end else if (take) begin
                lv_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        state_o      = st_q;
        pc_o         = pc_q;
        tag_o        = tag_q;
        line_valid_o = lv_q;
        rsp_take_o   = take;
        slot_ask_o   = enable_i && (st_q == FS_RUN) && refuse_i && !issue_i &&
                       !trap_i && !quiesce_i && !cmt_redir_i && !cmt_flush_i &&
                       !dec_redir_i && !stall_i;
        slot_leave_o = (st_q == FS_WAIT_RETRY) && (st_d != FS_WAIT_RETRY);
    end

    AST_COMMIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && cmt_redir_i) |=> (st_q == FS_SQUASH && pc_q == $past(cmt_pc_i))); // R3

    AST_STALE_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_here_i && st_q != FS_WAIT_RSP) |=> (st_q != FS_FILL_DONE)); // R9

    AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FS_WAIT_RSP && stall_i && enable_i && !cmt_redir_i && !cmt_flush_i &&
         !dec_redir_i && !rsp_here_i) |=> (st_q == FS_WAIT_RSP)); // R6

    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lv_q) |-> (st_q == FS_FILL_DONE || st_q == FS_BLOCK)); // R8

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NT    = 2,
    parameter int PC_W  = 32,
    parameter int TAG_W = 3,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT-1:0]        thr_enable,
    input  logic [4*NT-1:0]      stall_set,
    input  logic [4*NT-1:0]      stall_clr,
    input  logic                 ctx_switch,
    input  logic [NT-1:0]        cmt_redirect,
    input  logic [NT*PC_W-1:0]   cmt_redirect_pc,
    input  logic [NT-1:0]        cmt_flushing,
    input  logic [NT-1:0]        dec_redirect,
    input  logic [NT*PC_W-1:0]   dec_redirect_pc,
    input  logic [NT-1:0]        req_issue,
    input  logic [NT-1:0]        req_refuse,
    input  logic                 retry_grant,
    input  logic                 rsp_valid,
    input  logic [TID_W-1:0]     rsp_tid,
    input  logic [TAG_W-1:0]     rsp_tag,
    input  logic                 switched_out,
    input  logic [NT-1:0]        trap_req,
    input  logic [NT-1:0]        quiesce_req,
    input  logic [NT-1:0]        wake,
    output logic [4*NT-1:0]      thr_state,
    output logic [NT*PC_W-1:0]   thr_pc,
    output logic [NT*TAG_W-1:0]  req_tag,
    output logic [NT-1:0]        line_valid,
    output logic                 rsp_drop,
    output logic                 retry_busy,
    output logic [TID_W-1:0]     retry_owner,
    output logic                 stage_active
);

    logic [NT-1:0] take, ask, leave, won, grant_mine, stalled, in_retry, busy_thr;

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thr
            logic [STALL_SRC-1:0] flags;
            logic [STATE_W-1:0]   st;

            fsc_stall_flags #(.NSRC(STALL_SRC)) u_flags (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (stall_set[t*STALL_SRC +: STALL_SRC]),
                .clr_i  (stall_clr[t*STALL_SRC +: STALL_SRC]),
                .flag_o (flags)
            );

            assign stalled[t]    = ctx_switch | (|flags);
            assign grant_mine[t] = retry_grant && retry_busy && (retry_owner == TID_W'(t));

            fsc_thread_fsm #(.PC_W(PC_W), .TAG_W(TAG_W)) u_fsm (
                .clk            (clk),
                .rst_n          (rst_n),
                .enable_i       (thr_enable[t]),
                .stall_i        (stalled[t]),
                .cmt_redir_i    (cmt_redirect[t]),
                .cmt_pc_i       (cmt_redirect_pc[t*PC_W +: PC_W]),
                .cmt_flush_i    (cmt_flushing[t]),
                .dec_redir_i    (dec_redirect[t]),
                .dec_pc_i       (dec_redirect_pc[t*PC_W +: PC_W]),
                .issue_i        (req_issue[t]),
                .refuse_i       (req_refuse[t]),
                .slot_won_i     (won[t]),
                .grant_i        (grant_mine[t]),
                .trap_i         (trap_req[t]),
                .quiesce_i      (quiesce_req[t]),
                .wake_i         (wake[t]),
                .rsp_here_i     (rsp_valid && (rsp_tid == TID_W'(t))),
                .rsp_tag_i      (rsp_tag),
                .switched_out_i (switched_out),
                .state_o        (st),
                .pc_o           (thr_pc[t*PC_W +: PC_W]),
                .tag_o          (req_tag[t*TAG_W +: TAG_W]),
                .line_valid_o   (line_valid[t]),
                .rsp_take_o     (take[t]),
                .slot_ask_o     (ask[t]),
                .slot_leave_o   (leave[t])
            );

            assign thr_state[t*STATE_W +: STATE_W] = st;
            assign in_retry[t] = (st == FS_WAIT_RETRY);
            assign busy_thr[t] = thr_enable[t] &&
                                 (st == FS_RUN || st == FS_SQUASH || st == FS_FILL_DONE);
        end
    endgenerate

    fsc_retry_slot #(.NT(NT), .TID_W(TID_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .ask_i   (ask),
        .leave_i (leave),
        .won_o   (won),
        .busy_o  (retry_busy),
        .owner_o (retry_owner)
    );

    always_comb begin
        rsp_drop     = rsp_valid && !(|take);
        stage_active = |busy_thr;
    end

    AST_ONE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_retry)); // R10

    AST_OWNER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        retry_busy |-> in_retry[retry_owner]); // R10

    AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)); // R8

endmodule

// File: tb/sim_fetch_status_ctrl.sv
module sim_fetch_status_ctrl;

    localparam int NT = 2, PC_W = 32, TAG_W = 3, TID_W = 1;
    localparam logic [3:0] RUN = 0, IDLE = 1, SQ = 2, BLK = 3, WRSP = 4,
                           WRTY = 5, FDONE = 6, TRAP = 7, QUI = 8;

    logic clk = 0, rst_n = 0;
    logic [NT-1:0] thr_enable = '1;
    logic [4*NT-1:0] stall_set = '0, stall_clr = '0;
    logic ctx_switch = 0;
    logic [NT-1:0] cmt_redirect = '0, cmt_flushing = '0, dec_redirect = '0;
    logic [NT*PC_W-1:0] cmt_redirect_pc = '0, dec_redirect_pc = '0;
    logic [NT-1:0] req_issue = '0, req_refuse = '0, trap_req = '0, quiesce_req = '0, wake = '0;
    logic retry_grant = 0, rsp_valid = 0, switched_out = 0;
    logic [TID_W-1:0] rsp_tid = '0;
    logic [TAG_W-1:0] rsp_tag = '0;
    logic [4*NT-1:0] thr_state;
    logic [NT*PC_W-1:0] thr_pc;
    logic [NT*TAG_W-1:0] req_tag;
    logic [NT-1:0] line_valid;
    logic rsp_drop, retry_busy, stage_active;
    logic [TID_W-1:0] retry_owner;

    int checks = 0, fails = 0;

    always #5 clk = ~clk;

    fetch_status_ctrl #(.NT(NT), .PC_W(PC_W), .TAG_W(TAG_W)) u0 (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] st(input int t);
        return thr_state[t*4 +: 4];
    endfunction

    function automatic logic [31:0] pc(input int t);
        return thr_pc[t*PC_W +: PC_W];
    endfunction

    function automatic logic [2:0] tg(input int t);
        return req_tag[t*TAG_W +: TAG_W];
    endfunction

    task automatic send_rsp(input int t, input int tagv, input bit so, input bit exp_drop, input string msg);
        rsp_valid = 1; rsp_tid = TID_W'(t); rsp_tag = TAG_W'(tagv); switched_out = so;
        #1;
        chk(msg, rsp_drop, exp_drop);
        step();
        rsp_valid = 0; switched_out = 0;
    endtask

    task automatic t_reset();
        chk("R1 t0 state", st(0), RUN);
        chk("R1 t1 state", st(1), RUN);
        chk("R1 pc", pc(0), 0);
        chk("R1 tag", tg(1), 0);
        chk("R1 line_valid", line_valid, 0);
        chk("R1 retry_busy", retry_busy, 0);
        chk("R1 stage_active", stage_active, 1);
    endtask

    task automatic t_stall();
        stall_set[0] = 1; step(); stall_set[0] = 0;
        chk("R2 no effect same edge", st(0), RUN);
        step();
        chk("R6 decode stall blocks", st(0), BLK);
        chk("R6 other thread runs", st(1), RUN);
        stall_clr[0] = 1; step(); stall_clr[0] = 0;
        chk("R2 still blocked at clear edge", st(0), BLK);
        step();
        chk("R7 release to run", st(0), RUN);
        stall_set[4] = 1; stall_set[7] = 1; step(); stall_set = '0; step();
        stall_clr[4] = 1; step(); stall_clr = '0; step(); step();
        chk("R2 commit flag still sticky", st(1), BLK);
        stall_clr[7] = 1; step(); stall_clr = '0; step();
        chk("R7 t1 released", st(1), RUN);
    endtask

    task automatic t_ctx();
        ctx_switch = 1; step();
        chk("R6 ctx t0", st(0), BLK);
        chk("R6 ctx t1", st(1), BLK);
        chk("R12 inactive when all blocked", stage_active, 0);
        ctx_switch = 0; step();
        chk("R7 ctx release", st(1), RUN);
        chk("R12 active again", stage_active, 1);
    endtask

    task automatic t_cmt_squash();
        cmt_redirect[0] = 1; cmt_redirect_pc[31:0] = 32'h1000;
        dec_redirect[0] = 1; dec_redirect_pc[31:0] = 32'h2000;
        stall_set[1] = 1;
        step();
        cmt_redirect = '0; dec_redirect = '0; stall_set = '0;
        chk("R3 commit wins state", st(0), SQ);
        chk("R3 commit address", pc(0), 32'h1000);
        cmt_flushing[0] = 1; dec_redirect[0] = 1; dec_redirect_pc[31:0] = 32'h3000;
        step(); step();
        dec_redirect = '0;
        chk("R4 flushing holds", st(0), SQ);
        chk("R4 decode ignored while squashing", pc(0), 32'h1000);
        chk("R12 squash counts active", stage_active, 1);
        cmt_flushing = '0;
        stall_clr[1] = 1; step(); stall_clr = '0;
        chk("R6 stall after flush", st(0), BLK);
        step();
        chk("R7 back to run", st(0), RUN);
    endtask

    task automatic t_dec_squash();
        dec_redirect[1] = 1; dec_redirect_pc[63:32] = 32'h4400; step(); dec_redirect = '0;
        chk("R5 decode squash state", st(1), SQ);
        chk("R5 decode address", pc(1), 32'h4400);
        step();
        chk("R7 decode squash done", st(1), RUN);
    endtask

    task automatic t_miss();
        req_issue[0] = 1; step(); req_issue = '0;
        chk("R10 issue waits", st(0), WRSP);
        chk("R10 tag incremented", tg(0), 1);
        send_rsp(0, 0, 0, 1, "R9 wrong tag dropped");
        chk("R9 wrong tag keeps wait", st(0), WRSP);
        send_rsp(0, 1, 1, 1, "R9 switched out dropped");
        chk("R9 switched out keeps wait", st(0), WRSP);
        send_rsp(1, 0, 0, 1, "R9 non-waiting thread dropped");
        chk("R9 no fill on t1", line_valid[1], 0);
        send_rsp(0, 1, 0, 0, "R8 good fill accepted");
        chk("R8 fill done", st(0), FDONE);
        chk("R8 line valid", line_valid[0], 1);
        step();
        chk("R8 fill done to run", st(0), RUN);
    endtask

    task automatic t_miss_stall();
        req_issue[0] = 1; step(); req_issue = '0;
        chk("R10 second tag", tg(0), 2);
        chk("R10 line cleared on request", line_valid[0], 0);
        stall_set[0] = 1; step(); stall_set = '0; step();
        chk("R6 miss held under stall", st(0), WRSP);
        send_rsp(0, 2, 0, 0, "R8 fill under stall accepted");
        chk("R8 fill under stall blocks", st(0), BLK);
        chk("R8 line valid under stall", line_valid[0], 1);
        stall_clr[0] = 1; step(); stall_clr = '0; step();
        chk("R7 unblock after fill", st(0), RUN);
    endtask

    task automatic t_squash_miss();
        req_issue[0] = 1; step(); req_issue = '0;
        dec_redirect[0] = 1; dec_redirect_pc[31:0] = 32'h5000; step(); dec_redirect = '0;
        chk("R11 squash leaves miss", st(0), SQ);
        step();
        send_rsp(0, 3, 0, 1, "R11 abandoned response dropped");
        chk("R11 no fill", line_valid[0], 0);
        chk("R11 thread running", st(0), RUN);
    endtask

    task automatic t_retry();
        req_refuse = 2'b11; step(); req_refuse = '0;
        chk("R10 lowest wins slot", st(0), WRTY);
        chk("R10 loser stays running", st(1), RUN);
        chk("R10 slot busy", retry_busy, 1);
        chk("R10 owner", retry_owner, 0);
        chk("R10 winner tag", tg(0), 4);
        chk("R10 loser tag unchanged", tg(1), 0);
        req_refuse[1] = 1; step(); req_refuse = '0;
        chk("R10 busy slot refuses", st(1), RUN);
        cmt_redirect[0] = 1; cmt_redirect_pc[31:0] = 32'h6000; step(); cmt_redirect = '0;
        chk("R11 squash frees slot", retry_busy, 0);
        chk("R3 squash from retry", st(0), SQ);
        step();
        req_refuse[1] = 1; step(); req_refuse = '0;
        chk("R10 t1 takes slot", st(1), WRTY);
        chk("R10 owner t1", retry_owner, 1);
        retry_grant = 1; step(); retry_grant = 0;
        chk("R10 grant to wait", st(1), WRSP);
        chk("R10 grant frees slot", retry_busy, 0);
        cmt_redirect[1] = 1; step(); cmt_redirect = '0; step();
        chk("R7 t1 recovered", st(1), RUN);
    endtask

    task automatic t_trap();
        trap_req[0] = 1; quiesce_req[1] = 1; step(); trap_req = '0; quiesce_req = '0;
        chk("R13 trap", st(0), TRAP);
        chk("R13 quiesce", st(1), QUI);
        chk("R12 no work", stage_active, 0);
        step();
        chk("R13 trap held", st(0), TRAP);
        wake = 2'b11; step(); wake = '0;
        chk("R13 wake t0", st(0), RUN);
        chk("R13 wake t1", st(1), RUN);
    endtask

    task automatic t_idle();
        thr_enable = 2'b01; step();
        chk("R13 disabled idle", st(1), IDLE);
        chk("R12 one thread busy", stage_active, 1);
        thr_enable = 2'b00; step();
        chk("R12 none enabled", stage_active, 0);
        thr_enable = 2'b11; step();
        chk("R13 re-enabled runs", st(1), RUN);
        chk("R12 active after enable", stage_active, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_stall();
        t_ctx();
        t_cmt_squash();
        t_dec_squash();
        t_miss();
        t_miss_stall();
        t_squash_miss();
        t_retry();
        t_trap();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule